// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar from a slow tick input, 32.768 kHz by default, that arrives as a one-cycle enable in the system clock domain. A shared prescaler divides the tick stream into a once-per-second advance and a faster audio-rate strobe, 4096 Hz by default. Seven BCD registers hold seconds, minutes, hours, date, month, two-digit year and a weekday count. A carry chain moves the time forward and handles months of 30 and 31 days, February in leap and common years, and the wrap at the end of the century.

A host loads any register through a plain write strobe with an address and a byte. It reads any register back through a combinational read port that uses the same address. Each load restarts the sub-second prescaler. Alarm logic downstream can use the exported one-second pulse, the fast pulse and the packed time vector.

Top module: `rtc_calendar`

## Requirements
- R1: While reset is held and after it is released, the registers read 00 seconds, 00 minutes, 00 hours, date 01, month 01, year 00 and weekday 0, and both pulse outputs are low.
- R2: The time advances once for every TICK_HZ accepted ticks. `secPulse` is high for exactly one cycle, in the first cycle that shows the new time, and does not fire before the TICK_HZ-th tick.
- R3: Seconds and minutes count BCD 00 to 59 and hours count 00 to 23. Each wraps to 00 and carries into the next field. 23:59:59 wraps to 00:00:00 and moves to the next day.
- R4: The date runs from 01 to the month length, which is 30 for months 04, 06, 09 and 11 and 31 for 01, 03, 05, 07, 08, 10 and 12. Past the last day the date returns to 01 and the month increments in BCD. December wraps to January and the year increments.
- R5: February has 29 days when the binary value of the BCD year is divisible by four, including year 00. Otherwise it has 28.
- R6: The second after 23:59:59 on 31 December of year 99 is 00:00:00 on 01 January of year 00.
- R7: The weekday register increments at each midnight, independently of the date, and goes from 6 to 0. A write keeps only the low three bits, and a stored 7 advances to 0.
- R8: A write with `wrEn` high and `addr` equal to 0 (seconds), 1 (minutes), 2 (hours), 3 (date), 4 (month), 5 (year) or 6 (weekday) stores `wrData` at the next clock edge. It takes priority over a second advance in the same cycle and restarts the prescaler, so the next advance needs TICK_HZ further ticks. A write to address 7 changes no register.
- R9: `rdData` returns, with no added latency, the register selected by `addr` using the same codes as R8. The weekday is zero-extended and address 7 reads 0.
- R10: `tonePulse` is high for one cycle after every FAST_DIV-th tick counted from the last prescaler restart. FAST_DIV is a power of two that divides TICK_HZ.
- R11: `timeVec` packs the registers as {weekday, year, month, date, hours, minutes, seconds}, one byte each, with seconds in bits 7:0 and the weekday byte in bits 55:48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle enable per time-base tick |
| wrEn | input | 1 | Host write strobe |
| addr | input | 3 | Register select for write and read |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Selected register value |
| secPulse | output | 1 | One-cycle pulse when the time advances |
| tonePulse | output | 1 | One-cycle pulse at the fast strobe rate |
| timeVec | output | 56 | Packed current time and date |

## Verification
The carry chain is driven from preset times one tick before a second boundary. The presets are a plain seconds increment, a minute carry, an hour carry, and midnight in the middle of a month. They also include the last day of 30- and 31-day months, February 28 and 29 in years 00, 10, 12, 23 and 24, and the final second of year 99. Together these separate a binary leap test from a BCD-digit test, a wrong month-length table from a wrong carry, and a weekday tied to the date from a free-running one. Directed sequences then load a register partway through a second to show the prescaler restart. They also count fast pulses across a full second, store an out-of-range weekday, and write the unused address.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_W     = 8;
  localparam int FIELD_SEL_W = 3;
  localparam int TIME_VEC_W  = NUM_FIELDS * FIELD_W;

  typedef enum logic [FIELD_SEL_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DATE = 3'd3,
    F_MON  = 3'd4,
    F_YEAR = 3'd5,
    F_DOW  = 3'd6
  } fieldSel_e;

  // Strobes passed from the control side to the register datapath.
  typedef struct packed {
    logic                   advance;
    logic                   load;
    logic [FIELD_SEL_W-1:0] field;
  } ctrlStrobe_t;

  function automatic logic [FIELD_W-1:0] fieldResetVal(input int idx);
    if (idx == int'(F_DATE) || idx == int'(F_MON)) return 8'h01;
    return 8'h00;
  endfunction

  function automatic logic [FIELD_W-1:0] fieldWriteMask(input int idx);
    if (idx == int'(F_DOW)) return 8'h07;
    return 8'hFF;
  endfunction

  // Adds one to a two-digit BCD value (no wrap check here).
  function automatic logic [FIELD_W-1:0] bcdStep(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl
  import rtc_pkg::*;
#(
  parameter int TICK_HZ  = 32768,
  parameter int FAST_DIV = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickIn,
  input  logic                   wrEn,
  input  logic [FIELD_SEL_W-1:0] wrAddr,
  output ctrlStrobe_t            strb,
  output logic                   secPulse,
  output logic                   tonePulse
);
  localparam int CNT_W  = (TICK_HZ > 1) ? $clog2(TICK_HZ) : 1;
  localparam int FAST_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

  logic [CNT_W-1:0] subCnt;
  logic             lastTick;
  logic             loadHit;
  logic             fastEdge;
  logic             toneHit;

  assign lastTick = (subCnt == CNT_W'(TICK_HZ - 1));
  assign loadHit  = wrEn && (wrAddr < FIELD_SEL_W'(NUM_FIELDS));

  generate
    if (FAST_DIV == 1) begin : gFastAll
      assign fastEdge = 1'b1;
    end else begin : gFastDiv
      assign fastEdge = (subCnt[FAST_W-1:0] == FAST_W'(FAST_DIV - 1));
    end
  endgenerate

  assign toneHit      = tickIn && fastEdge && !loadHit;
  assign strb.advance = tickIn && lastTick && !loadHit;
  assign strb.load    = loadHit;
  assign strb.field   = wrAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt    <= '0;
      secPulse  <= 1'b0;
      tonePulse <= 1'b0;
    end else begin
      if (loadHit)     subCnt <= '0;
      else if (tickIn) subCnt <= lastTick ? '0 : subCnt + CNT_W'(1);
      secPulse  <= strb.advance;
      tonePulse <= toneHit;
    end
  end

  // Two advances can never be adjacent when a second spans many ticks.
  assert_sec_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> !strb.advance);

  // A register load restarts the second, so no advance directly follows it.
  assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !strb.advance);

  // A second boundary always coincides with a fast-strobe boundary.
  assert_tone_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> tonePulse);
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [FIELD_W-1:0]     wrData,
  input  logic [FIELD_SEL_W-1:0] rdAddr,
  output logic [FIELD_W-1:0]     rdData,
  output logic [TIME_VEC_W-1:0]  timeVec
);
  logic [FIELD_W-1:0] fieldQ  [NUM_FIELDS];
  logic [FIELD_W-1:0] nextAdv [NUM_FIELDS];

  logic [6:0]         yearBin;
  logic               leapYear;
  logic [FIELD_W-1:0] lastDate;
  logic               secWrap, minWrap, hourWrap, dateWrap, monWrap;

  // Year is two BCD digits; the leap test runs on its binary value.
  assign yearBin  = {3'b000, fieldQ[F_YEAR][7:4]} * 7'd10 + {3'b000, fieldQ[F_YEAR][3:0]};
  assign leapYear = (yearBin[1:0] == 2'b00);

  always_comb begin
    case (fieldQ[F_MON])
      8'h02:                      lastDate = leapYear ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDate = 8'h30;
      default:                    lastDate = 8'h31;
    endcase
  end

  // Carry chain; >= comparisons recover from out-of-range host loads.
  assign secWrap  = (fieldQ[F_SEC]  >= 8'h59);
  assign minWrap  = secWrap  && (fieldQ[F_MIN]  >= 8'h59);
  assign hourWrap = minWrap  && (fieldQ[F_HOUR] >= 8'h23);
  assign dateWrap = hourWrap && (fieldQ[F_DATE] >= lastDate);
  assign monWrap  = dateWrap && (fieldQ[F_MON]  >= 8'h12);

  always_comb begin
    nextAdv[F_SEC]  = secWrap ? 8'h00 : bcdStep(fieldQ[F_SEC]);
    nextAdv[F_MIN]  = !secWrap ? fieldQ[F_MIN] :
                      (minWrap ? 8'h00 : bcdStep(fieldQ[F_MIN]));
    nextAdv[F_HOUR] = !minWrap ? fieldQ[F_HOUR] :
                      (hourWrap ? 8'h00 : bcdStep(fieldQ[F_HOUR]));
    nextAdv[F_DATE] = !hourWrap ? fieldQ[F_DATE] :
                      (dateWrap ? 8'h01 : bcdStep(fieldQ[F_DATE]));
    nextAdv[F_MON]  = !dateWrap ? fieldQ[F_MON] :
                      (monWrap ? 8'h01 : bcdStep(fieldQ[F_MON]));
    nextAdv[F_YEAR] = !monWrap ? fieldQ[F_YEAR] :
                      ((fieldQ[F_YEAR] >= 8'h99) ? 8'h00 : bcdStep(fieldQ[F_YEAR]));
    nextAdv[F_DOW]  = !hourWrap ? fieldQ[F_DOW] :
                      ((fieldQ[F_DOW] >= 8'h06) ? 8'h00 : fieldQ[F_DOW] + 8'h01);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_FIELDS; g++) begin : gField
      logic [FIELD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rstN)
          q <= fieldResetVal(g);
        else if (strb.load && (strb.field == FIELD_SEL_W'(g)))
          q <= wrData & fieldWriteMask(g);
        else if (strb.advance)
          q <= nextAdv[g];
      end
      assign fieldQ[g] = q;
      assign timeVec[g*FIELD_W +: FIELD_W] = q;
    end
  endgenerate

  assign rdData = (rdAddr < FIELD_SEL_W'(NUM_FIELDS)) ? fieldQ[rdAddr] : '0;

  // Seconds wrap from 59 back to 00.
  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && fieldQ[F_SEC] == 8'h59) |=> (fieldQ[F_SEC] == 8'h00));

  // Weekday 6 becomes 0 at midnight.
  assert_dow_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && fieldQ[F_SEC] == 8'h59 && fieldQ[F_MIN] == 8'h59 &&
     fieldQ[F_HOUR] == 8'h23 && fieldQ[F_DOW] == 8'h06) |=> (fieldQ[F_DOW] == 8'h00));

  // Leaving 29 February always lands on 01 March.
  assert_feb_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && fieldQ[F_SEC] == 8'h59 && fieldQ[F_MIN] == 8'h59 &&
     fieldQ[F_HOUR] == 8'h23 && fieldQ[F_MON] == 8'h02 && fieldQ[F_DATE] == 8'h29)
    |=> (fieldQ[F_MON] == 8'h03 && fieldQ[F_DATE] == 8'h01));

  // End of year 99 wraps the whole calendar.
  assert_century_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && fieldQ[F_SEC] == 8'h59 && fieldQ[F_MIN] == 8'h59 &&
     fieldQ[F_HOUR] == 8'h23 && fieldQ[F_DATE] == 8'h31 &&
     fieldQ[F_MON] == 8'h12 && fieldQ[F_YEAR] == 8'h99)
    |=> (fieldQ[F_YEAR] == 8'h00 && fieldQ[F_MON] == 8'h01 && fieldQ[F_DATE] == 8'h01));

  // Without load or advance every register holds.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.advance) |=> $stable(timeVec));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICK_HZ  = 32768,
  parameter int FAST_DIV = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        secPulse,
  output logic        tonePulse,
  output logic [55:0] timeVec
);
  ctrlStrobe_t strb;

  rtc_tick_ctrl #(
    .TICK_HZ (TICK_HZ),
    .FAST_DIV(FAST_DIV)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .wrEn     (wrEn),
    .wrAddr   (addr),
    .strb     (strb),
    .secPulse (secPulse),
    .tonePulse(tonePulse)
  );

  rtc_time_regs regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdAddr (addr),
    .rdData (rdData),
    .timeVec(timeVec)
  );

  // Every second pulse shows a changed seconds byte.
  assert_pulse_change_R2: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> !$stable(timeVec[7:0]));
endmodule

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
  localparam int TB_TICK_HZ  = 16;
  localparam int TB_FAST_DIV = 4;
  localparam int NUM_VEC     = 15;

  // {preset, expected one second later}; bytes: dow,year,month,date,hour,min,sec
  localparam logic [111:0] VECS [NUM_VEC] = '{
    {56'h02_00_01_01_00_00_05, 56'h02_00_01_01_00_00_06},  // R2 plain step
    {56'h03_24_06_15_10_00_59, 56'h03_24_06_15_10_01_00},  // R3 minute carry
    {56'h03_24_06_15_10_59_59, 56'h03_24_06_15_11_00_00},  // R3 hour carry
    {56'h03_24_06_15_23_59_59, 56'h04_24_06_16_00_00_00},  // R3 R7 midnight
    {56'h01_24_04_30_23_59_59, 56'h02_24_05_01_00_00_00},  // R4 30-day month
    {56'h06_23_01_31_23_59_59, 56'h00_23_02_01_00_00_00},  // R4 R7 31-day, dow wrap
    {56'h00_24_02_28_23_59_59, 56'h01_24_02_29_00_00_00},  // R5 leap 24
    {56'h01_24_02_29_23_59_59, 56'h02_24_03_01_00_00_00},  // R5 leap exit
    {56'h05_23_02_28_23_59_59, 56'h06_23_03_01_00_00_00},  // R5 common 23
    {56'h04_00_02_28_23_59_59, 56'h05_00_02_29_00_00_00},  // R5 year 00
    {56'h02_10_02_28_23_59_59, 56'h03_10_03_01_00_00_00},  // R5 year 10 common
    {56'h03_99_12_31_23_59_59, 56'h04_00_01_01_00_00_00},  // R6 century
    {56'h03_19_12_31_23_59_59, 56'h04_20_01_01_00_00_00},  // R4 year step
    {56'h00_24_09_30_23_59_59, 56'h01_24_10_01_00_00_00},  // R4 month 09->10
    {56'h02_12_02_28_23_59_59, 56'h03_12_02_29_00_00_00}   // R5 year 12 leap
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wrData = 8'd0;
  logic [7:0]  rdData;
  logic        secPulse;
  logic        tonePulse;
  logic [55:0] timeVec;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar #(.TICK_HZ(TB_TICK_HZ), .FAST_DIV(TB_FAST_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .secPulse(secPulse),
    .tonePulse(tonePulse), .timeVec(timeVec)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) tickOnce();
  endtask

  task automatic loadAll(input logic [55:0] t);
    for (int f = 0; f < 7; f++) writeReg(3'(f), t[f*8 +: 8]);
  endtask

  task automatic readCheck(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, 64'(rdData), 64'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 64'(timeVec), 64'h00_00_01_01_00_00_00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 64'(timeVec), 64'h00_00_01_01_00_00_00);
    check("R1 pulses low", 64'({secPulse, tonePulse}), 64'd0);

    // Vector table: preset, confirm no early advance, then one tick completes the second.
    for (int v = 0; v < NUM_VEC; v++) begin
      loadAll(VECS[v][111:56]);
      check("R11 loaded", 64'(timeVec), 64'(VECS[v][111:56]));
      tickN(TB_TICK_HZ - 1);
      check("R2 no early advance", 64'(timeVec), 64'(VECS[v][111:56]));
      check("R2 pulse idle", 64'(secPulse), 64'd0);
      tickOnce();
      check($sformatf("R3/R4/R5/R6/R7 vector %0d", v), 64'(timeVec), 64'(VECS[v][55:0]));
      check("R2 pulse", 64'(secPulse), 64'd1);
      @(negedge clk);
      check("R2 pulse one cycle", 64'(secPulse), 64'd0);
    end

    // R9 read port on state from the last vector, plus unused address.
    readCheck("R9 sec", 3'd0, 8'h00);
    readCheck("R9 date", 3'd3, 8'h29);
    readCheck("R9 month", 3'd4, 8'h02);
    readCheck("R9 year", 3'd5, 8'h12);
    readCheck("R9 dow", 3'd6, 8'h03);
    readCheck("R9 addr7", 3'd7, 8'h00);

    // R8 write to address 7 has no effect on any register.
    writeReg(3'd7, 8'hFF);
    check("R8 addr7 ignored", 64'(timeVec), 64'h03_12_02_29_00_00_00);

    // R8 write mid-second restarts the prescaler.
    tickN(10);
    writeReg(3'd0, 8'h30);
    tickN(TB_TICK_HZ - 1);
    check("R8 restart hold", 64'(timeVec[7:0]), 64'h30);
    tickOnce();
    check("R8 restart advance", 64'(timeVec[7:0]), 64'h31);

    // R10 fast strobe every FAST_DIV ticks after a restart.
    writeReg(3'd0, 8'h00);
    for (int k = 1; k <= TB_TICK_HZ; k++) begin
      tickOnce();
      check($sformatf("R10 tone tick %0d", k), 64'(tonePulse), 64'((k % TB_FAST_DIV) == 0));
    end
    check("R10 second at end", 64'(secPulse), 64'd1);

    // R7 weekday keeps low three bits; 7 advances to 0 at midnight.
    writeReg(3'd6, 8'hFF);
    readCheck("R7 dow masked", 3'd6, 8'h07);
    writeReg(3'd2, 8'h23);
    writeReg(3'd1, 8'h59);
    writeReg(3'd0, 8'h59);
    tickN(TB_TICK_HZ);
    check("R7 dow 7 wraps", 64'(timeVec[55:48]), 64'h00);
    check("R5 leap exit directed", 64'(timeVec[39:24]), 64'h03_01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule